// File: doc/BRIEF.md
# Fast interrupt request latch

This block turns an active-low external fast-interrupt pin into a sticky pending flag and an active-low fast-interrupt line toward the processor. The pin is brought into the clock domain through a synchronizer. Depending on a mode bit, the block records either a high-to-low transition of the synchronized pin or every cycle in which the pin is held low. Once recorded, the flag stays set until software clears it.

A small control register holds three bits. Bit 0 is the pending flag, which software clears by writing one. Bit 1 is the mask, which is read/write. Bit 2 is the detection mode, which is read/write. While the mask is clear and the flag is set, the processor line is driven low from a register, so it never glitches. Software reads the flag in its handler, clears it by writing one, and the line returns high. Setting the mask hides the request from the processor, but the flag remains visible in the register.

Top module: `fiq_latch`

## Requirements
- R1: After reset, the register reads 3'b010: flag (bit 0) = 0, mask (bit 1) = 1, mode (bit 2) = 0 (edge). The `cpu_fiq_n` output is 1.
- R2: In edge mode (bit 2 = 0), a high-to-low transition of the pin sets the flag. If the pin is first sampled low at clock edge k, the flag reads 1 after edge k+2.
- R3: In edge mode, a pin held low sets the flag only once. After a write-one clear, the flag stays 0 until the pin goes high and then low again.
- R4: In level mode (bit 2 = 1), the flag is set on every cycle in which the synchronized pin is low, so a clear has no lasting effect while the pin stays low.
- R5: While the mask (bit 1) is 1, `cpu_fiq_n` stays 1, and a pending flag still reads back as 1.
- R6: `cpu_fiq_n` is a register. It goes low on the edge after the flag reads 1 with the mask at 0, and it goes high on the edge after either of those conditions ends.
- R7: A write with bit 0 = 1 clears the flag on that edge, so `cpu_fiq_n` returns to 1 one edge later.
- R8: A write with bit 0 = 0 leaves the flag unchanged.
- R9: If a new request and a write-one clear fall on the same edge, the flag stays set.
- R10: The mask and mode bits take the value of write data bits 1 and 2 on every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fiq_n | input | 1 | Active-low external request pin, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 3 | Write data: {mode, mask, clear-flag} |
| reg_rdata | output | 3 | Read data: {mode, mask, flag} |
| cpu_fiq_n | output | 1 | Active-low fast-interrupt request to the processor |

## Verification
The assertions assume that `reg_wdata` matters only while `reg_wr` is high. They also assume that reset is applied before the first request, so the synchronizer begins in its idle-high state. The bench changes the pin and the register inputs only just after the falling clock edge, so every rising edge samples settled values. The bench also lines up one request with a clear write on the same edge, which exercises the collision rule on purpose.

// File: rtl/fiq_latch.sv
module fiq_latch #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_fiq_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_wdata,
  output logic [2:0] reg_rdata,
  output logic       cpu_fiq_n
);

  logic [SYNC:0] sh;
  logic          flag, mask, mode;
  logic          synced, prev, hit, clr;

  assign synced = sh[SYNC-1];
  assign prev   = sh[SYNC];
  assign hit    = mode ? !synced : (prev && !synced);
  assign clr    = reg_wr && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC-1:0], ext_fiq_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag <= 1'b0;
      mask <= 1'b1;
      mode <= 1'b0;
    end else begin
      flag <= hit || (flag && !clr);
      if (reg_wr) begin
        mask <= reg_wdata[1];
        mode <= reg_wdata[2];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cpu_fiq_n <= 1'b1;
    else        cpu_fiq_n <= !(flag && !mask);

  assign reg_rdata = {mode, mask, flag};

  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] && !(reg_wr && reg_wdata[0]) |=> reg_rdata[0]);

  a_r9_request_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit && reg_wr && reg_wdata[0] |=> reg_rdata[0]);

  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |=> cpu_fiq_n);

  a_r6_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] && !reg_rdata[1] |=> !cpu_fiq_n);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0] |=> cpu_fiq_n);

  a_r10_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[2:1] == $past(reg_wdata[2:1]));

  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2] && !synced |=> reg_rdata[0]);

endmodule

// File: tb/tb_fiq_latch.sv
module tb_fiq_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       wr = 1'b0;
  logic [2:0] wd = 3'b000;
  logic [2:0] rd;
  logic       nfiq;

  always #5 clk = ~clk;

  fiq_latch dut (.clk(clk), .rst_n(rst_n), .ext_fiq_n(pin), .reg_wr(wr),
                 .reg_wdata(wd), .reg_rdata(rd), .cpu_fiq_n(nfiq));

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string phase = "R1";

  bit m_flag = 0, m_mask = 1, m_mode = 0, m_nfiq = 1;
  bit hist[$] = '{1'b1, 1'b1, 1'b1};

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{1'b1, 1'b1, 1'b1};
      m_flag = 0; m_mask = 1; m_mode = 0; m_nfiq = 1;
    end else begin
      bit ev;
      ev = m_mode ? (hist[1] == 1'b0) : (hist[2] == 1'b1 && hist[1] == 1'b0);
      m_nfiq = !(m_flag && !m_mask);
      m_flag = ev || (m_flag && !(wr && wd[0]));
      if (wr) begin m_mask = wd[1]; m_mode = wd[2]; end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) if (!done) begin
    compared++;
    if (rd !== {m_mode, m_mask, m_flag} || nfiq !== m_nfiq) begin
      mismatched++;
      $display("FAIL %s: rdata=%b nfiq=%b expected rdata=%b nfiq=%b",
               phase, rd, nfiq, {m_mode, m_mask, m_flag}, m_nfiq);
    end
  end

  task automatic expect_val(string tag, logic [3:0] act, logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [2:0] v);
    @(negedge clk); wr = 1'b1; wd = v;
    @(negedge clk); wr = 1'b0; wd = 3'b000;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    expect_val("R1", {nfiq, rd}, 4'b1010);

    phase = "R10"; write(3'b000); cycles(2);
    expect_val("R10", {1'b0, rd}, 4'b0000);

    phase = "R2"; pin = 1'b0; cycles(2);
    expect_val("R2", {3'b000, rd[0]}, 4'b0000);
    cycles(1);
    expect_val("R2", {3'b000, rd[0]}, 4'b0001);
    phase = "R6"; cycles(1);
    expect_val("R6", {3'b000, nfiq}, 4'b0000);
    phase = "R3"; write(3'b001); cycles(5);
    expect_val("R3", {nfiq, rd}, 4'b1000);
    pin = 1'b1; cycles(4);

    phase = "R5"; write(3'b010);
    pin = 1'b0; cycles(3); pin = 1'b1; cycles(5);
    expect_val("R5", {nfiq, rd}, 4'b1011);
    phase = "R8"; write(3'b010); cycles(2);
    expect_val("R8", {nfiq, rd}, 4'b1011);
    phase = "R6"; write(3'b000); cycles(2);
    expect_val("R6", {nfiq, rd}, 4'b0001);
    phase = "R7"; write(3'b001); cycles(1);
    expect_val("R7", {nfiq, rd}, 4'b1000);

    phase = "R9"; cycles(3);
    @(negedge clk); pin = 1'b0;
    @(negedge clk); @(negedge clk);
    wr = 1'b1; wd = 3'b001;
    @(negedge clk); wr = 1'b0; wd = 3'b000;
    expect_val("R9", {3'b000, rd[0]}, 4'b0001);
    pin = 1'b1; cycles(4); write(3'b001); cycles(2);

    phase = "R4"; write(3'b100);
    pin = 1'b0; cycles(4);
    write(3'b101); cycles(2);
    expect_val("R4", {nfiq, rd}, 4'b0101);
    pin = 1'b1; cycles(4); write(3'b101); cycles(2);
    expect_val("R4", {nfiq, rd}, 4'b1100);

    phase = "R2";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pin = ($urandom % 4) != 0;
      wr  = ($urandom % 6) == 0;
      wd  = 3'($urandom);
    end
    @(negedge clk); wr = 1'b0; pin = 1'b1;
    cycles(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule